// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers a set of interrupt request lines, organised as groups of equal width, plus one non-maskable request. On every cycle in which the sample enable is high, each line is registered into the request register of its group. The registered lines of a group are then ORed into one group-pending flag. Priority is assigned per group, not per line. Software therefore reads the group's request register to learn which line inside the group is active, and it chooses among several active lines itself.

Each group owns a priority register. The register places the group on one of four levels, INT3 being the most urgent and INT0 the least, and holds an autovector offset for the group. The processor's per-level mask bits and its global mask bit qualify the pending levels. The block then presents the highest unmasked level and the autovector of the group that wins it. Within a level, the group with the lowest number wins. One cause register per level reports whether the level has a pending group and which offset that group carries. The non-maskable request overrides every mask and every level.

A single-cycle register port writes the priority registers and reads the priority, request and cause registers. The read path is combinational.

Top module: `grp_intc`

## Requirements
- R1: During and after a synchronous active-low reset, all request registers, the non-maskable sample and all priority registers read as zero, and irq_valid and irq_nmi are low.
- R2: On a rising edge with sample_en high, line g*GROUP_W+i is stored into bit i of group g's request register. That register reads at address {2'b01, g}, where bits [3:2] select the space and bits [1:0] the index. The value is visible from the cycle after that edge.
- R3: While sample_en is low, the request registers and the non-maskable sample hold their values. Sampling resumes on the first edge with sample_en high.
- R4: Writing address {2'b00, g} sets group g's level from data bits [31:30] and its offset from bits [13:0]. The register reads back with all other bits zero. Writes to any other space change no register.
- R5: A group counts as pending when any bit of its request register is set, whichever bit that is.
- R6: The cause register of level L reads at {2'b10, L}. Bit 31 is set when any group on level L is pending, and bits [13:0] hold the offset of the lowest-numbered such group. The register reads zero when no group on level L is pending. The masks do not affect it.
- R7: Without the non-maskable request, irq_valid is high when an unmasked level has a pending group. irq_level and irq_autovec then give the highest such level and its winning group's offset.
- R8: A level is blocked when its bit in cpu_lvl_mask is set or when cpu_gm is set. When every pending level is blocked, irq_valid is low.
- R9: When several pending groups share the winning level, the lowest-numbered group supplies irq_autovec.
- R10: A sampled non-maskable request sets irq_nmi and irq_valid and forces irq_level to 3 and irq_autovec to NMI_VEC (zero by default). This holds regardless of cpu_gm, cpu_lvl_mask and any pending groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | Enable for the request sampling stage; low models its gated clock |
| irq_lines | input | NUM_GROUPS*GROUP_W | Interrupt request lines, group-major |
| nmi_line | input | 1 | Non-maskable request |
| cpu_lvl_mask | input | 4 | Processor mask bit per level, bit L blocks level L |
| cpu_gm | input | 1 | Processor global mask |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register write address |
| cfg_wdata | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| irq_valid | output | 1 | An interrupt is offered to the processor |
| irq_nmi | output | 1 | The offered interrupt is the non-maskable one |
| irq_level | output | 2 | Level of the offered interrupt |
| irq_autovec | output | OFF_W | Autovector offset of the offered interrupt |

## Verification
The assertions assume that the inputs change only between clock edges. They also assume that sample_en and nmi_line are defined whenever rst_n is high, because the hold and non-maskable entry properties relate the input seen at one edge to the state at the next. The bench drives every input on the falling edge and samples results after a short settle. Any change of a mask that must be judged alone is made while the request registers are stable.

// File: rtl/grp_intc_pkg.sv
// Shared constants and types for the grouped interrupt controller.
// Assumes a 32-bit register port and exactly four priority levels.
package grp_intc_pkg;
    localparam int DATA_W     = 32;
    localparam int NUM_LEVELS = 4;
    localparam int LVL_W      = 2;
    localparam int LVL_HI     = 31;
    localparam int LVL_LO     = 30;
    localparam int PEND_BIT   = 31;

    // Register space selected by the top two address bits.
    typedef enum logic [1:0] {
        SPACE_PRIO  = 2'd0,
        SPACE_REQ   = 2'd1,
        SPACE_CAUSE = 2'd2,
        SPACE_NONE  = 2'd3
    } space_e;
endpackage

// File: rtl/grp_intc_sampler.sv
// Request sampling stage: registers every request line into its group's
// request register while sample_en is high, holds otherwise, and ORs each
// group into a pending flag. Assumes inputs already synchronous to clk.
module grp_intc_sampler #(
    parameter int NUM_GROUPS = 2,
    parameter int GROUP_W    = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 sample_en,
    input  logic [NUM_GROUPS*GROUP_W-1:0]        irq_lines,
    input  logic                                 nmi_line,
    output logic [NUM_GROUPS-1:0][GROUP_W-1:0]   req_q,
    output logic                                 nmi_q,
    output logic [NUM_GROUPS-1:0]                grp_pend
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        // Capture this group's lines when the sampling clock runs.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_q[g] <= '0;
            end else if (sample_en) begin
                req_q[g] <= irq_lines[g*GROUP_W +: GROUP_W];
            end
        end

        // Any active line makes the group pending.
        assign grp_pend[g] = |req_q[g];
    end

    // Capture the non-maskable request with the same enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q <= 1'b0;
        end else if (sample_en) begin
            nmi_q <= nmi_line;
        end
    end
endmodule

// File: rtl/grp_intc_prio_regs.sv
// Per-group priority registers holding a level and an autovector offset.
// Assumes the caller has already decoded the write to the priority space.
module grp_intc_prio_regs
    import grp_intc_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int OFF_W      = 14,
    parameter int IDX_W      = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic [DATA_W-1:0]                   wr_data,
    output logic [NUM_GROUPS-1:0][LVL_W-1:0]    grp_lvl,
    output logic [NUM_GROUPS-1:0][OFF_W-1:0]    grp_off
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_reg
        // Load level and offset fields when this group is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                grp_lvl[g] <= '0;
                grp_off[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                grp_lvl[g] <= wr_data[LVL_HI:LVL_LO];
                grp_off[g] <= wr_data[OFF_W-1:0];
            end
        end
    end
endmodule

// File: rtl/grp_intc_level_resolve.sv
// For each level, finds whether any pending group sits on it and picks the
// offset of the lowest-numbered one. Masks are not applied here.
module grp_intc_level_resolve
    import grp_intc_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int OFF_W      = 14
) (
    input  logic [NUM_GROUPS-1:0]               grp_pend,
    input  logic [NUM_GROUPS-1:0][LVL_W-1:0]    grp_lvl,
    input  logic [NUM_GROUPS-1:0][OFF_W-1:0]    grp_off,
    output logic [NUM_LEVELS-1:0]               lvl_pend,
    output logic [NUM_LEVELS-1:0][OFF_W-1:0]    lvl_off
);
    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
        // Scan groups downward so the lowest number is the last to win.
        always_comb begin
            lvl_pend[l] = 1'b0;
            lvl_off[l]  = '0;
            for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
                if (grp_pend[g] && (grp_lvl[g] == LVL_W'(l))) begin
                    lvl_pend[l] = 1'b1;
                    lvl_off[l]  = grp_off[g];
                end
            end
        end
    end
endmodule

// File: rtl/grp_intc_arbiter.sv
// Applies the processor masks, picks the highest unmasked level, and lets
// the non-maskable request override everything.
module grp_intc_arbiter
    import grp_intc_pkg::*;
#(
    parameter int               OFF_W   = 14,
    parameter logic [OFF_W-1:0] NMI_VEC = '0
) (
    input  logic [NUM_LEVELS-1:0]               lvl_pend,
    input  logic [NUM_LEVELS-1:0][OFF_W-1:0]    lvl_off,
    input  logic [NUM_LEVELS-1:0]               lvl_mask,
    input  logic                                gm,
    input  logic                                nmi_q,
    output logic                                out_valid,
    output logic                                out_nmi,
    output logic [LVL_W-1:0]                    out_level,
    output logic [OFF_W-1:0]                    out_vec
);
    logic [NUM_LEVELS-1:0] eligible;

    // A level may compete only when pending and not blocked by a mask.
    always_comb begin
        for (int l = 0; l < NUM_LEVELS; l++) begin
            eligible[l] = lvl_pend[l] && !lvl_mask[l] && !gm;
        end
    end

    // Ascending scan: the highest eligible level is the last assignment.
    always_comb begin
        out_valid = 1'b0;
        out_nmi   = 1'b0;
        out_level = '0;
        out_vec   = '0;
        for (int l = 0; l < NUM_LEVELS; l++) begin
            if (eligible[l]) begin
                out_valid = 1'b1;
                out_level = LVL_W'(l);
                out_vec   = lvl_off[l];
            end
        end
        if (nmi_q) begin
            out_valid = 1'b1;
            out_nmi   = 1'b1;
            out_level = LVL_W'(NUM_LEVELS - 1);
            out_vec   = NMI_VEC;
        end
    end
endmodule

// File: rtl/grp_intc.sv
// Grouped priority interrupt controller top. Ties the sampling stage, the
// priority registers, the per-level resolver and the mask arbiter together
// and provides the register port. Assumes GROUP_W and OFF_W fit in 32 bits
// and OFF_W stays below bit 30.
module grp_intc
    import grp_intc_pkg::*;
#(
    parameter int               NUM_GROUPS = 2,
    parameter int               GROUP_W    = 32,
    parameter int               OFF_W      = 14,
    parameter logic [OFF_W-1:0] NMI_VEC    = '0,
    localparam int GSEL_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int IDX_W  = (GSEL_W > LVL_W) ? GSEL_W : LVL_W,
    localparam int ADDR_W = 2 + IDX_W,
    localparam int LINES  = NUM_GROUPS * GROUP_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_en,
    input  logic [LINES-1:0]     irq_lines,
    input  logic                 nmi_line,
    input  logic [3:0]           cpu_lvl_mask,
    input  logic                 cpu_gm,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [31:0]          cfg_wdata,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [31:0]          rd_data,
    output logic                 irq_valid,
    output logic                 irq_nmi,
    output logic [1:0]           irq_level,
    output logic [OFF_W-1:0]     irq_autovec
);
    logic [NUM_GROUPS-1:0][GROUP_W-1:0] req_q;
    logic                               nmi_q;
    logic [NUM_GROUPS-1:0]              grp_pend;
    logic [NUM_GROUPS-1:0][LVL_W-1:0]   grp_lvl;
    logic [NUM_GROUPS-1:0][OFF_W-1:0]   grp_off;
    logic [NUM_LEVELS-1:0]              lvl_pend;
    logic [NUM_LEVELS-1:0][OFF_W-1:0]   lvl_off;
    space_e                             wr_space;
    space_e                             rd_space;
    logic [IDX_W-1:0]                   wr_idx;
    logic [IDX_W-1:0]                   rd_idx;
    logic                               prio_we;

    assign wr_space = space_e'(cfg_addr[ADDR_W-1 -: 2]);
    assign wr_idx   = cfg_addr[IDX_W-1:0];
    assign rd_space = space_e'(rd_addr[ADDR_W-1 -: 2]);
    assign rd_idx   = rd_addr[IDX_W-1:0];
    assign prio_we  = cfg_we && (wr_space == SPACE_PRIO);

    grp_intc_sampler #(
        .NUM_GROUPS (NUM_GROUPS),
        .GROUP_W    (GROUP_W)
    ) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .irq_lines (irq_lines),
        .nmi_line  (nmi_line),
        .req_q     (req_q),
        .nmi_q     (nmi_q),
        .grp_pend  (grp_pend)
    );

    grp_intc_prio_regs #(
        .NUM_GROUPS (NUM_GROUPS),
        .OFF_W      (OFF_W),
        .IDX_W      (IDX_W)
    ) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (prio_we),
        .wr_idx  (wr_idx),
        .wr_data (cfg_wdata),
        .grp_lvl (grp_lvl),
        .grp_off (grp_off)
    );

    grp_intc_level_resolve #(
        .NUM_GROUPS (NUM_GROUPS),
        .OFF_W      (OFF_W)
    ) u_resolve (
        .grp_pend (grp_pend),
        .grp_lvl  (grp_lvl),
        .grp_off  (grp_off),
        .lvl_pend (lvl_pend),
        .lvl_off  (lvl_off)
    );

    grp_intc_arbiter #(
        .OFF_W   (OFF_W),
        .NMI_VEC (NMI_VEC)
    ) u_arb (
        .lvl_pend  (lvl_pend),
        .lvl_off   (lvl_off),
        .lvl_mask  (cpu_lvl_mask),
        .gm        (cpu_gm),
        .nmi_q     (nmi_q),
        .out_valid (irq_valid),
        .out_nmi   (irq_nmi),
        .out_level (irq_level),
        .out_vec   (irq_autovec)
    );

    // Read multiplexer over the priority, request and cause spaces.
    always_comb begin
        rd_data = '0;
        unique case (rd_space)
            SPACE_PRIO: begin
                if (int'(rd_idx) < NUM_GROUPS) begin
                    rd_data[LVL_HI:LVL_LO] = grp_lvl[rd_idx[GSEL_W-1:0]];
                    rd_data[OFF_W-1:0]     = grp_off[rd_idx[GSEL_W-1:0]];
                end
            end
            SPACE_REQ: begin
                if (int'(rd_idx) < NUM_GROUPS) begin
                    rd_data[GROUP_W-1:0] = req_q[rd_idx[GSEL_W-1:0]];
                end
            end
            SPACE_CAUSE: begin
                if (int'(rd_idx) < NUM_LEVELS) begin
                    rd_data[PEND_BIT]   = lvl_pend[rd_idx[LVL_W-1:0]];
                    rd_data[OFF_W-1:0]  = lvl_off[rd_idx[LVL_W-1:0]];
                end
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/grp_intc_chk.sv
// Property checker for grp_intc, attached with bind. Relates sampled
// inputs, internal request state and the offered interrupt over time.
module grp_intc_chk #(
    parameter int REQ_BITS = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sample_en,
    input logic                nmi_line,
    input logic [3:0]          cpu_lvl_mask,
    input logic                cpu_gm,
    input logic                irq_valid,
    input logic                irq_nmi,
    input logic [1:0]          irq_level,
    input logic [REQ_BITS-1:0] req_q,
    input logic                nmi_q
);
    AST_HOLD_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> ($stable(req_q) && $stable(nmi_q)));                         // R3

    AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q == '0 && !nmi_q) |-> !irq_valid);                                   // R5

    AST_MASKED_LEVEL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !irq_nmi) |-> (!cpu_gm && !cpu_lvl_mask[irq_level]));        // R8

    AST_NMI_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_line && sample_en) |=> (irq_nmi && irq_valid && irq_level == 2'd3));  // R10

    AST_NMI_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nmi |-> irq_valid);                                                    // R10
endmodule

bind grp_intc grp_intc_chk #(
    .REQ_BITS (NUM_GROUPS * GROUP_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_en    (sample_en),
    .nmi_line     (nmi_line),
    .cpu_lvl_mask (cpu_lvl_mask),
    .cpu_gm       (cpu_gm),
    .irq_valid    (irq_valid),
    .irq_nmi      (irq_nmi),
    .irq_level    (irq_level),
    .req_q        (req_q),
    .nmi_q        (nmi_q)
);

// File: tb/grp_intc_bench.sv
// Directed bench for grp_intc: one task per scenario, each checking itself.
module grp_intc_bench;
    localparam int NG = 2;
    localparam int GW = 32;
    localparam int OW = 14;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sample_en = 1'b1;
    logic [NG*GW-1:0] irq_lines = '0;
    logic            nmi_line = 1'b0;
    logic [3:0]      cpu_lvl_mask = 4'h0;
    logic            cpu_gm = 1'b0;
    logic            cfg_we = 1'b0;
    logic [3:0]      cfg_addr = '0;
    logic [31:0]     cfg_wdata = '0;
    logic [3:0]      rd_addr = '0;
    logic [31:0]     rd_data;
    logic            irq_valid;
    logic            irq_nmi;
    logic [1:0]      irq_level;
    logic [OW-1:0]   irq_autovec;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    grp_intc u_grp_intc (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .irq_lines(irq_lines),
        .nmi_line(nmi_line), .cpu_lvl_mask(cpu_lvl_mask), .cpu_gm(cpu_gm),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_valid(irq_valid),
        .irq_nmi(irq_nmi), .irq_level(irq_level), .irq_autovec(irq_autovec)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock edge, then settle on the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] space, input logic [1:0] idx, output logic [31:0] d);
        rd_addr = {space, idx};
        #1;
        d = rd_data;
    endtask

    task automatic wr(input logic [1:0] space, input logic [1:0] idx, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = {space, idx}; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    // Packs the offered interrupt for comparison: {valid, nmi, level, vec}.
    function automatic logic [31:0] offer();
        return {12'd0, irq_valid, irq_nmi, irq_level, 2'd0, irq_autovec};
    endfunction

    function automatic logic [31:0] exp_offer(bit v, bit n, logic [1:0] l, logic [OW-1:0] o);
        return {12'd0, v, n, l, 2'd0, o};
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        #1;
        check("R1 irq_valid", 32'(irq_valid), 32'd0);
        check("R1 irq_nmi", 32'(irq_nmi), 32'd0);
        rd(2'd1, 2'd0, d); check("R1 request g0", d, 32'd0);
        rd(2'd0, 2'd1, d); check("R1 priority g1", d, 32'd0);
    endtask

    task automatic t_sample();
        logic [31:0] d;
        irq_lines[5] = 1'b1;
        irq_lines[40] = 1'b1;
        #1;
        check("R2 not visible before edge", 32'(irq_valid), 32'd0);
        tick();
        rd(2'd1, 2'd0, d); check("R2 request g0", d, 32'h0000_0020);
        rd(2'd1, 2'd1, d); check("R2 request g1", d, 32'h0000_0100);
    endtask

    task automatic t_gate();
        logic [31:0] d;
        sample_en = 1'b0;
        irq_lines = '0;
        nmi_line = 1'b1;
        tick(); tick();
        rd(2'd1, 2'd0, d); check("R3 held g0", d, 32'h0000_0020);
        check("R3 nmi not sampled", 32'(irq_nmi), 32'd0);
        nmi_line = 1'b0;
        sample_en = 1'b1;
        tick();
        rd(2'd1, 2'd0, d); check("R3 resumed g0", d, 32'd0);
        check("R3 resumed idle", 32'(irq_valid), 32'd0);
    endtask

    task automatic t_prio();
        logic [31:0] d;
        wr(2'd0, 2'd0, 32'h8FFF_C123);
        rd(2'd0, 2'd0, d); check("R4 readback fields", d, 32'h8000_0123);
        rd(2'd0, 2'd1, d); check("R4 other group untouched", d, 32'd0);
        wr(2'd1, 2'd0, 32'hFFFF_FFFF);
        wr(2'd2, 2'd1, 32'hFFFF_FFFF);
        rd(2'd1, 2'd0, d); check("R4 request space not writable", d, 32'd0);
        rd(2'd0, 2'd0, d); check("R4 priority unchanged", d, 32'h8000_0123);
        rd(2'd2, 2'd1, d); check("R4 cause space not writable", d, 32'd0);
    endtask

    task automatic t_arb();
        logic [31:0] d;
        wr(2'd0, 2'd0, 32'h4000_0010);
        wr(2'd0, 2'd1, 32'h8000_0020);
        irq_lines[3] = 1'b1;
        irq_lines[33] = 1'b1;
        tick();
        check("R7 highest level", offer(), exp_offer(1, 0, 2'd2, 14'h20));
        rd(2'd2, 2'd1, d); check("R6 cause level1", d, 32'h8000_0010);
        rd(2'd2, 2'd2, d); check("R6 cause level2", d, 32'h8000_0020);
        rd(2'd2, 2'd3, d); check("R6 cause level3 empty", d, 32'd0);
        cpu_lvl_mask = 4'b0100;
        #1;
        check("R8 level2 masked", offer(), exp_offer(1, 0, 2'd1, 14'h10));
        rd(2'd2, 2'd2, d); check("R6 cause ignores mask", d, 32'h8000_0020);
        cpu_lvl_mask = 4'b0110;
        #1;
        check("R8 all pending masked", 32'(irq_valid), 32'd0);
        cpu_lvl_mask = 4'b0000;
        cpu_gm = 1'b1;
        #1;
        check("R8 global mask", 32'(irq_valid), 32'd0);
        cpu_gm = 1'b0;
        #1;
    endtask

    task automatic t_tie();
        logic [31:0] d;
        wr(2'd0, 2'd0, 32'hC000_0010);
        wr(2'd0, 2'd1, 32'hC000_0020);
        check("R9 lowest group wins", offer(), exp_offer(1, 0, 2'd3, 14'h10));
        irq_lines[3] = 1'b0;
        irq_lines[31] = 1'b1;
        tick();
        check("R5 other line keeps group pending", offer(), exp_offer(1, 0, 2'd3, 14'h10));
        irq_lines[31] = 1'b0;
        tick();
        check("R9 next group after clear", offer(), exp_offer(1, 0, 2'd3, 14'h20));
        rd(2'd2, 2'd3, d); check("R6 cause level3", d, 32'h8000_0020);
    endtask

    task automatic t_nmi();
        nmi_line = 1'b1;
        tick();
        check("R10 nmi over pending level", offer(), exp_offer(1, 1, 2'd3, 14'h0));
        cpu_gm = 1'b1;
        cpu_lvl_mask = 4'hF;
        #1;
        check("R10 nmi ignores masks", offer(), exp_offer(1, 1, 2'd3, 14'h0));
        nmi_line = 1'b0;
        tick();
        check("R10 nmi released, masked", 32'(irq_valid), 32'd0);
        cpu_gm = 1'b0;
        cpu_lvl_mask = 4'h0;
    endtask

    initial begin
        rst_n = 1'b0;
        tick(); tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_sample();
        t_gate();
        t_prio();
        t_arb();
        t_tie();
        t_nmi();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule